// File: doc/BRIEF.md
# Frame transfer handshake controller

This block sits between an image capture path and an external compression processor and paces whole frames across that boundary. After reset it waits for a start command. It then stores a fixed number of preprocessed pixel words into one internal FIFO. Each time the FIFO fills to half its depth, it asks the processor for a DMA transfer. The processor empties the FIFO through a show-ahead read port.

Once the frame is captured, the controller waits for the processor to write the compressed frame back into the same FIFO and to raise an interrupt. The interrupt arrives asynchronously and is synchronized and edge-detected. On that interrupt the controller streams a fixed number of compressed words to its output. It then samples an encode-valid input. If the input is high, the next frame is captured at once without a new command. If it is low, the controller pulses an end notification and goes back to idle.

The frame length must be a whole multiple of half the FIFO depth, so that every captured word is covered by a DMA request.

Top module: `frame_xfer_ctrl`

## Requirements
- R1: After reset, `dma_req`, `out_valid` and `end_notify` are low. Pixels offered before a start command are not stored. `start_cmd` is acted on only while idle, and a command during capture leaves the frame length unchanged.
- R2: Accepted pixel words are read back by the processor in arrival order. `dma_rd_data` shows the oldest word, and `dma_rd_en` removes it when the FIFO is not empty.
- R3: During capture, `dma_req` goes high on the same clock edge that stores the word bringing occupancy to DEPTH/2 or above.
- R4: `dma_req` stays high until a cycle with `dma_ack` high, and is low on the following cycle. An acknowledge while no request is pending has no effect.
- R5: A new request is raised only after occupancy has dropped below DEPTH/2 and then reaches DEPTH/2 again within the same capture.
- R6: Capture ends after FRAME_WORDS accepted pixels, and pixels offered later are not stored. A pixel offered while the FIFO holds DEPTH words is discarded and does not count toward the frame.
- R7: `cmp_irq` is synchronized through two flops and acts on its rising edge only, and only after capture has finished. An interrupt held high starts one readback, and an interrupt during capture produces no output.
- R8: Compressed words written through `cmp_wr_en` are accepted only after capture has ended. After the interrupt exactly CMP_WORDS of them appear on `out_data` with `out_valid`, in write order.
- R9: When the last compressed word is output, `enc_valid` high starts a new capture with no command and no end pulse. `enc_valid` low gives a one-cycle `end_notify` pulse and a return to idle.
- R10: During readback, `dma_rd_en` does not remove words, so the output sequence stays complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cmd | input | 1 | Acquisition command, acted on when idle |
| pix_valid | input | 1 | Pixel word present |
| pix_data | input | DATA_W | Preprocessed pixel word |
| dma_req | output | 1 | DMA transfer request to the processor |
| dma_ack | input | 1 | One-cycle acknowledge of the request |
| dma_rd_en | input | 1 | Processor pop strobe on the FIFO |
| dma_rd_data | output | DATA_W | Oldest FIFO word (show-ahead) |
| cmp_irq | input | 1 | Asynchronous compression-done interrupt |
| cmp_wr_en | input | 1 | Processor write strobe for compressed data |
| cmp_wr_data | input | DATA_W | Compressed data word |
| enc_valid | input | 1 | Continue-encoding flag, sampled at the end of readback |
| out_valid | output | 1 | Compressed output word present |
| out_data | output | DATA_W | Compressed output word |
| end_notify | output | 1 | One-cycle pulse telling the processor to stop |

## Verification
The hardest state to reach is a FIFO that is completely full while a request is still pending and the pixel stream continues. In that state, discarded words must neither be stored nor counted, and the request must not be raised twice. The stimulus reaches it by deliberately withholding the acknowledge for more than DEPTH pixels, then draining everything at once and finishing the frame. That run also shows whether dropped pixels shifted the end of capture, because a shifted end makes the later interrupt fall in the wrong state. A second hard case is an interrupt held high through a whole readback and into the next frame. It is driven on a chained frame so that any second edge would show up as extra output words.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CAPTURE  = 2'd1,
        ST_WAIT_IRQ = 2'd2,
        ST_READBACK = 2'd3
    } fxc_state_e;
endpackage

// File: rtl/fxc_fifo.sv
module fxc_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count,
    output logic [CW-1:0]     count_nxt,
    output logic              full,
    output logic              empty
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_regs_t;

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    fifo_regs_t r_q, r_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        r_d   = r_q;
        full  = (r_q.count == FULL_LVL);
        empty = (r_q.count == '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        if (do_wr) r_d.wr_ptr = r_q.wr_ptr + 1'b1;
        if (do_rd) r_d.rd_ptr = r_q.rd_ptr + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[r_q.wr_ptr] <= wr_data;
    end

    assign rd_data   = mem[r_q.rd_ptr];
    assign count     = r_q.count;
    assign count_nxt = r_d.count;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.count == $past(r_q.count)) || (r_q.count == $past(r_q.count) + 1'b1) ||
        (r_q.count == $past(r_q.count) - 1'b1));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (r_q.count == FULL_LVL));
endmodule

// File: rtl/fxc_irq_sync.sv
module fxc_irq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_async,
    output logic irq_edge
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_regs_t;

    sync_regs_t s_q, s_d;

    always_comb begin
        s_d.meta = irq_async;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
        irq_edge = s_q.sync && !s_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |=> !irq_edge);
endmodule

// File: rtl/fxc_dma_req.sv
module fxc_dma_req #(
    parameter int CW   = 5,
    parameter int HALF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capturing,
    input  logic          arm,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] level_nxt,
    input  logic          ack,
    output logic          req
);
    typedef struct packed {
        logic req;
        logic armed;
    } req_regs_t;

    localparam logic [CW-1:0] HALF_LVL = CW'(HALF);

    req_regs_t r_q, r_d;
    logic below, raise;

    always_comb begin
        r_d   = r_q;
        below = (level < HALF_LVL);
        raise = capturing && !r_q.req && (r_q.armed || below) && (level_nxt >= HALF_LVL);
        if (ack && r_q.req) r_d.req = 1'b0;
        if (raise) begin
            r_d.req   = 1'b1;
            r_d.armed = 1'b0;
        end else if (arm || below) begin
            r_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req = r_q.req;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !ack) |=> r_q.req);

    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && ack) |=> !r_q.req);

    // R3
    raise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.req) |-> (level >= HALF_LVL));
endmodule

// File: rtl/frame_xfer_ctrl.sv
module frame_xfer_ctrl
    import fxc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 16,
    parameter int FRAME_WORDS = 32,
    parameter int CMP_WORDS   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic              dma_rd_en,
    output logic [DATA_W-1:0] dma_rd_data,
    input  logic              cmp_irq,
    input  logic              cmp_wr_en,
    input  logic [DATA_W-1:0] cmp_wr_data,
    input  logic              enc_valid,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              end_notify
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;
    localparam int FW   = $clog2(FRAME_WORDS + 1);
    localparam int RW   = $clog2(CMP_WORDS + 1);
    localparam logic [FW-1:0] CAP_LAST = FW'(FRAME_WORDS - 1);
    localparam logic [RW-1:0] RB_LAST  = RW'(CMP_WORDS - 1);

    typedef struct packed {
        fxc_state_e        state;
        logic [FW-1:0]     cap_cnt;
        logic [RW-1:0]     rb_cnt;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic              end_p;
    } ctrl_regs_t;

    ctrl_regs_t c_q, c_d;

    logic              f_wr, f_rd, f_full, f_empty;
    logic [DATA_W-1:0] f_wdata, f_rdata;
    logic [CW-1:0]     f_count, f_count_nxt;
    logic              irq_edge, arm;
    logic              pix_take, cmp_take, rb_pop, dma_pop;

    fxc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (f_wr),
        .wr_data   (f_wdata),
        .rd_en     (f_rd),
        .rd_data   (f_rdata),
        .count     (f_count),
        .count_nxt (f_count_nxt),
        .full      (f_full),
        .empty     (f_empty)
    );

    fxc_irq_sync u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_async (cmp_irq),
        .irq_edge  (irq_edge)
    );

    fxc_dma_req #(.CW(CW), .HALF(HALF)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .capturing (c_q.state == ST_CAPTURE),
        .arm       (arm),
        .level     (f_count),
        .level_nxt (f_count_nxt),
        .ack       (dma_ack),
        .req       (dma_req)
    );

    always_comb begin
        c_d           = c_q;
        c_d.out_valid = 1'b0;
        c_d.end_p     = 1'b0;
        arm           = 1'b0;

        pix_take = (c_q.state == ST_CAPTURE) && pix_valid && !f_full;
        cmp_take = ((c_q.state == ST_WAIT_IRQ) || (c_q.state == ST_READBACK)) &&
                   cmp_wr_en && !f_full;
        rb_pop   = (c_q.state == ST_READBACK) && !f_empty;
        dma_pop  = (c_q.state != ST_READBACK) && dma_rd_en;

        f_wr    = pix_take || cmp_take;
        f_wdata = pix_take ? pix_data : cmp_wr_data;
        f_rd    = rb_pop || dma_pop;

        case (c_q.state)
            ST_IDLE: begin
                if (start_cmd) begin
                    c_d.state   = ST_CAPTURE;
                    c_d.cap_cnt = '0;
                    arm         = 1'b1;
                end
            end
            ST_CAPTURE: begin
                if (pix_take) begin
                    c_d.cap_cnt = c_q.cap_cnt + 1'b1;
                    if (c_q.cap_cnt == CAP_LAST) c_d.state = ST_WAIT_IRQ;
                end
            end
            ST_WAIT_IRQ: begin
                if (irq_edge) begin
                    c_d.state  = ST_READBACK;
                    c_d.rb_cnt = '0;
                end
            end
            ST_READBACK: begin
                if (rb_pop) begin
                    c_d.out_valid = 1'b1;
                    c_d.out_data  = f_rdata;
                    c_d.rb_cnt    = c_q.rb_cnt + 1'b1;
                    if (c_q.rb_cnt == RB_LAST) begin
                        if (enc_valid) begin
                            c_d.state   = ST_CAPTURE;
                            c_d.cap_cnt = '0;
                            arm         = 1'b1;
                        end else begin
                            c_d.state = ST_IDLE;
                            c_d.end_p = 1'b1;
                        end
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign dma_rd_data = f_rdata;
    assign out_valid   = c_q.out_valid;
    assign out_data    = c_q.out_data;
    assign end_notify  = c_q.end_p;

    // R9
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.end_p |=> !c_q.end_p);

    // R8
    out_in_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.out_valid |-> ($past(c_q.state) == ST_READBACK));

    // R1
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.state == ST_IDLE) && $past(c_q.state == ST_IDLE) && !$past(dma_req)) |-> !dma_req);

    // R9
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.end_p |-> (c_q.state == ST_IDLE));
endmodule

// File: tb/test_frame_xfer_ctrl.sv
module test_frame_xfer_ctrl;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;
    localparam int FRAME = 32;
    localparam int CMP   = 6;
    localparam int NVEC  = 4;
    // [23:8] pixel base, [7] enc_valid, [5:0] interrupt hold cycles
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0100, 1'b1, 1'b0, 6'd40},
        {16'h2000, 1'b0, 1'b0, 6'd3},
        {16'h5500, 1'b1, 1'b0, 6'd2},
        {16'hA0A0, 1'b0, 1'b0, 6'd5}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_cmd = 0, pix_valid = 0, dma_ack = 0, dma_rd_en = 0;
    logic cmp_irq = 0, cmp_wr_en = 0, enc_valid = 0;
    logic [DW-1:0] pix_data = '0, cmp_wr_data = '0;
    logic dma_req, out_valid, end_notify;
    logic [DW-1:0] dma_rd_data, out_data;

    int n_vec = 0, n_err = 0;
    logic [DW-1:0] q[$];
    bit m_req = 0, m_armed = 0, m_cap = 0;
    int m_words = 0;

    always #2 clk = ~clk;

    frame_xfer_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .FRAME_WORDS(FRAME), .CMP_WORDS(CMP)) i_frame_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .pix_valid(pix_valid), .pix_data(pix_data),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_rd_en(dma_rd_en), .dma_rd_data(dma_rd_data),
        .cmp_irq(cmp_irq), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data), .enc_valid(enc_valid),
        .out_valid(out_valid), .out_data(out_data), .end_notify(end_notify));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] cmpv(input logic [DW-1:0] base, input int i);
        return ~base + DW'(i * 3);
    endfunction

    task automatic cmd();
        start_cmd = 1; @(negedge clk); start_cmd = 0;
        if (!m_cap && m_words == 0) begin m_cap = 1; m_armed = 1; end
    endtask

    task automatic push(input logic [DW-1:0] v);
        int occ;
        occ = q.size();
        pix_valid = 1; pix_data = v; @(negedge clk); pix_valid = 0;
        if (m_cap && occ < DEPTH) begin
            q.push_back(v);
            m_words++;
            if (!m_req && (m_armed || occ < HALF) && occ + 1 >= HALF) begin
                m_req = 1; m_armed = 0;
            end else if (occ < HALF) m_armed = 1;
            if (m_words == FRAME) m_cap = 0;
        end else if (occ < HALF) m_armed = 1;
        chk(dma_req == m_req, "R3 R5 R6 request level", dma_req, m_req);
    endtask

    task automatic serve();
        int n;
        chk(dma_req == 1'b1, "R3 request before ack", dma_req, 1);
        dma_ack = 1; @(negedge clk); dma_ack = 0; m_req = 0;
        chk(dma_req == 1'b0, "R4 request dropped after ack", dma_req, 0);
        n = q.size();
        for (int i = 0; i < n; i++) begin
            dma_rd_en = 1;
            chk(dma_rd_data == q[0], "R2 read order", dma_rd_data, q[0]);
            void'(q.pop_front());
            @(negedge clk);
            if (q.size() < HALF) m_armed = 1;
        end
        dma_rd_en = 0;
    endtask

    task automatic feed(input logic [DW-1:0] base, input int n, input bit auto_serve);
        for (int i = 0; i < n; i++) begin
            push(base + DW'(i));
            if (auto_serve && m_req) serve();
        end
    endtask

    task automatic readback(input bit enc, input int hold);
        int idx, ends;
        logic [DW-1:0] base;
        base = 16'h3C5A ^ DW'(hold);
        for (int i = 0; i < CMP; i++) begin
            cmp_wr_en = 1; cmp_wr_data = cmpv(base, i); @(negedge clk);
        end
        cmp_wr_en = 0;
        enc_valid = enc;
        cmp_irq = 1;
        idx = 0; ends = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (c == hold) cmp_irq = 0;
            if (out_valid) begin
                dma_rd_en = 1;
                chk(out_data == cmpv(base, idx), "R8 R10 output word", out_data, cmpv(base, idx));
                idx++;
            end
            if (end_notify) ends++;
        end
        cmp_irq = 0; dma_rd_en = 0;
        chk(idx == CMP, "R7 R8 output word count", idx, CMP);
        chk(ends == (enc ? 0 : 1), "R9 end pulse count", ends, enc ? 0 : 1);
        if (enc) begin m_cap = 1; m_words = 0; m_armed = 1; end
        else m_words = 0;
    endtask

    initial begin
        #(4ns * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        bit prev_enc;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(dma_req == 0, "R1 reset req", dma_req, 0);
        chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        chk(end_notify == 0, "R1 reset end_notify", end_notify, 0);
        // R1 pixels before command are not stored; R4 ack with nothing pending
        push(16'hDEAD);
        dma_ack = 1; @(negedge clk); dma_ack = 0;
        chk(dma_req == 0, "R4 idle ack ignored", dma_req, 0);

        prev_enc = 0;
        for (int v = 0; v < NVEC; v++) begin
            if (!prev_enc) cmd();
            feed(VEC[v][23:8], FRAME, 1);
            if (v == 0) begin
                push(16'hBEEF); // R6 pixel after capture end must not reach output
                chk(dma_req == 0, "R6 no request after capture", dma_req, 0);
            end
            readback(VEC[v][7], int'(VEC[v][5:0]));
            prev_enc = VEC[v][7];
        end

        // R6 directed: full FIFO with request pending, extra pixels dropped
        cmd();
        feed(16'h7000, DEPTH + 4, 0);
        cmd(); // R1 ignored during capture
        serve();
        feed(16'h7100, FRAME - DEPTH, 1);
        readback(0, 4);

        // R7 directed: interrupt during capture has no effect
        cmd();
        feed(16'h9000, 3, 1);
        cmp_irq = 1;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c == 3) cmp_irq = 0;
            chk(out_valid == 0, "R7 irq in capture ignored", out_valid, 0);
        end
        feed(16'h9003, FRAME - 3, 1);
        readback(0, 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule